// File: doc/BRIEF.md
# Oscilloscope Edge and Pulse-Width Trigger

This block decides when a two-channel, 8-bit sampling oscilloscope should start a capture. It watches one source at a time: channel 1, channel 2 or an external digital trigger pin. Each analog channel is turned into a clean logic level by a comparator with hysteresis. The level rises when a sample reaches the upper threshold. It falls when a sample reaches the lower threshold. Between the two thresholds the previous level is kept, so noise near one threshold cannot chatter the trigger. The external pin is synchronised and skips the comparator.

On the chosen level the block fires on a rising edge or a falling edge. It can also fire on a positive or negative pulse whose width, counted in sample clocks, is below or above a programmable limit. The limit is 32 bits wide and is loaded as two halves: the upper half first, then the lower half. The lower-half write commits the full value. The output is a single-cycle strobe. After it fires, the block stays disarmed until the re-arm input is asserted. One sample is taken per clock.

Top module: `scope_trig`

## Requirements
- R1: After reset `trig_out` is 0, the block is armed, the upper threshold is 0xC0, the lower threshold is 0x40, the settings select channel 1 with a rising-edge trigger and a less-than test, and the pulse limit is 0.
- R2: A channel's level goes to 1 when its sample is >= the upper threshold (`thr_data[15:8]`). It goes to 0 when its sample is <= the lower threshold (`thr_data[7:0]`). Otherwise it keeps its previous value.
- R3: Settings bits [1:0] pick the source: 00 channel 1, 01 channel 2, 10 external. A source that is not selected has no effect on `trig_out`.
- R4: The external input passes through two synchroniser flops and no comparator. A rising edge on `ext_in` ahead of clock edge N gives `trig_out` = 1 after edge N+2.
- R5: Settings bits [3:2] = 00 fire on a rising level and 01 on a falling level. A sample applied ahead of clock edge N gives `trig_out` = 1 after edge N+1.
- R6: Settings bits [3:2] = 10 select a positive pulse and 11 a negative pulse. The width is the number of clocks the level spent in the pulse state, and it is tested when the pulse ends. Settings bit 4 = 0 fires when the width is < the limit; bit 4 = 1 fires when the width is > the limit.
- R7: A `lim_hi_wr` write only loads a shadow register. The pulse limit becomes {shadow, `lim_data`} on a `lim_lo_wr` write.
- R8: `trig_out` is high for exactly one cycle. After firing with `rearm` low, no further trigger occurs until `rearm` has been sampled high.
- R9: The pulse-width counter saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch1_smp | input | DW | Channel 1 sample |
| ch2_smp | input | DW | Channel 2 sample |
| ext_in | input | 1 | Asynchronous external trigger pin |
| thr_wr | input | 1 | Load threshold word |
| thr_data | input | 2*DW | Upper threshold [15:8], lower threshold [7:0] |
| cfg_wr | input | 1 | Load settings word |
| cfg_data | input | 5 | [4] width test sign, [3:2] trigger type, [1:0] source |
| lim_hi_wr | input | 1 | Load upper half of the pulse limit into the shadow register |
| lim_lo_wr | input | 1 | Load lower half and commit the full limit |
| lim_data | input | CNT_W/2 | Limit half being written |
| rearm | input | 1 | Re-enable triggering |
| trig_out | output | 1 | Single-cycle trigger strobe |

## Verification
The hardest condition to reach from the ports is counter saturation. With a 32-bit width, saturation would need billions of clocks. The bench therefore adds a second instance built with an 8-bit counter. It drives a 300-clock pulse against a limit of 254 with the greater-than test. That instance fires only if the counter held at 255 rather than wrapping to 44. Pulse-width boundaries are probed with widths equal to the limit and one either side. The half-written limit case is reached by pulsing only the upper-half write between two measurements.

// File: rtl/scope_trig_pkg.sv
// Package: shared encodings for the oscilloscope trigger.
// Assumes the settings word is 5 bits: sign[4], type[3:2], source[1:0].
package scope_trig_pkg;

    typedef enum logic [1:0] {
        SRC_CH1  = 2'b00,
        SRC_CH2  = 2'b01,
        SRC_EXT  = 2'b10,
        SRC_RSVD = 2'b11
    } trig_src_e;

    typedef enum logic [1:0] {
        TT_RISE   = 2'b00,
        TT_FALL   = 2'b01,
        TT_PPULSE = 2'b10,
        TT_NPULSE = 2'b11
    } trig_type_e;

    typedef struct packed {
        logic       sign;
        trig_type_e ttype;
        trig_src_e  src;
    } trig_cfg_t;

endpackage

// File: rtl/st_hyst.sv
// Module: hysteresis comparator turning a sample stream into a level.
// Assumes one sample per clock; when the thresholds overlap, the upper one wins.
module st_hyst #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] smp,
    input  logic [DW-1:0] thr_hi,
    input  logic [DW-1:0] thr_lo,
    output logic          lvl
);

    // Set on reaching the upper threshold, clear on reaching the lower one, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl <= 1'b0;
        else if (smp >= thr_hi)
            lvl <= 1'b1;
        else if (smp <= thr_lo)
            lvl <= 1'b0;
    end

endmodule

// File: rtl/st_sync.sv
// Module: multi-flop synchroniser for an asynchronous single-bit input.
// Assumes STAGES >= 2 and a slowly changing input.
module st_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sr_q;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else
            sr_q <= {sr_q[STAGES-2:0], din};
    end

    assign dout = sr_q[STAGES-1];

endmodule

// File: rtl/st_detect.sv
// Module: edge and pulse-width detector with a one-shot, re-armable output.
// Assumes the level input is already synchronous.
// A pulse is judged on the clock its trailing edge is seen.
module st_detect
    import scope_trig_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  trig_type_e       ttype,
    input  logic             sign,
    input  logic [CNT_W-1:0] limit,
    input  logic             rearm,
    output logic             trig,
    output logic             armed
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic             act_now, act_prev, width_ok, fire;

    // A negative pulse is a positive pulse of the inverted level.
    assign act_now  = (ttype == TT_NPULSE) ? ~lvl    : lvl;
    assign act_prev = (ttype == TT_NPULSE) ? ~prev_q : prev_q;
    assign width_ok = sign ? (cnt_q > limit) : (cnt_q < limit);

    // Pick the firing condition for the selected trigger type.
    always_comb begin
        unique case (ttype)
            TT_RISE: fire = lvl & ~prev_q;
            TT_FALL: fire = ~lvl & prev_q;
            default: fire = act_prev & ~act_now & width_ok;
        endcase
    end

    // Remember the previous level and count the width of the active phase, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            prev_q <= lvl;
            if (act_now)
                cnt_q <= act_prev ? ((cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1)
                                  : CNT_W'(1);
        end
    end

    // Emit a one-cycle strobe when armed; disarm until rearm is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig  <= 1'b0;
            armed <= 1'b1;
        end else begin
            trig <= fire & armed;
            if (rearm)
                armed <= 1'b1;
            else if (fire)
                armed <= 1'b0;
        end
    end

endmodule

// File: rtl/scope_trig.sv
// Module: oscilloscope trigger top. It holds the threshold, settings and
// pulse-limit registers, conditions both channels and the external pin,
// and selects one source for the detector.
// Assumes one sample per clock. The reserved source code 11 behaves as external.
module scope_trig
    import scope_trig_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DW-1:0]        ch1_smp,
    input  logic [DW-1:0]        ch2_smp,
    input  logic                 ext_in,
    input  logic                 thr_wr,
    input  logic [2*DW-1:0]      thr_data,
    input  logic                 cfg_wr,
    input  logic [4:0]           cfg_data,
    input  logic                 lim_hi_wr,
    input  logic                 lim_lo_wr,
    input  logic [CNT_W/2-1:0]   lim_data,
    input  logic                 rearm,
    output logic                 trig_out
);

    localparam int HALF_W = CNT_W / 2;
    localparam int NCH    = 2;
    localparam logic [DW-1:0] THR_HI_RST = DW'(3 << (DW - 2));
    localparam logic [DW-1:0] THR_LO_RST = DW'(1 << (DW - 2));

    logic [DW-1:0]     thr_hi_q, thr_lo_q;
    trig_cfg_t         cfg_q;
    logic [HALF_W-1:0] lim_shadow_q;
    logic [CNT_W-1:0]  lim_q;
    logic [DW-1:0]     smp [NCH];
    logic [NCH-1:0]    lvl;
    logic              ext_lvl, src_lvl, armed_q;

    // Threshold and settings registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_hi_q <= THR_HI_RST;
            thr_lo_q <= THR_LO_RST;
            cfg_q    <= '0;
        end else begin
            if (thr_wr) begin
                thr_hi_q <= thr_data[2*DW-1:DW];
                thr_lo_q <= thr_data[DW-1:0];
            end
            if (cfg_wr)
                cfg_q <= trig_cfg_t'(cfg_data);
        end
    end

    // Pulse limit: the upper half waits in a shadow until the lower half commits both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_shadow_q <= '0;
            lim_q        <= '0;
        end else begin
            if (lim_hi_wr)
                lim_shadow_q <= lim_data;
            if (lim_lo_wr)
                lim_q <= {lim_shadow_q, lim_data};
        end
    end

    assign smp[0] = ch1_smp;
    assign smp[1] = ch2_smp;

    // One hysteresis comparator per analog channel.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        st_hyst #(.DW(DW)) u_hyst (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp    (smp[c]),
            .thr_hi (thr_hi_q),
            .thr_lo (thr_lo_q),
            .lvl    (lvl[c])
        );
    end

    st_sync #(.STAGES(2)) u_ext_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_in),
        .dout  (ext_lvl)
    );

    // Select the trigger source level.
    always_comb begin
        unique case (cfg_q.src)
            SRC_CH1: src_lvl = lvl[0];
            SRC_CH2: src_lvl = lvl[1];
            default: src_lvl = ext_lvl;
        endcase
    end

    st_detect #(.CNT_W(CNT_W)) u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (src_lvl),
        .ttype (cfg_q.ttype),
        .sign  (cfg_q.sign),
        .limit (lim_q),
        .rearm (rearm),
        .trig  (trig_out),
        .armed (armed_q)
    );

endmodule

// File: rtl/scope_trig_chk.sv
// Module: assertion checker bound to scope_trig.
// It observes ports and register state only.
module scope_trig_chk #(
    parameter int DW    = 8,
    parameter int CNT_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rearm,
    input logic                 trig_out,
    input logic                 armed_q,
    input logic                 lim_hi_wr,
    input logic                 lim_lo_wr,
    input logic [CNT_W/2-1:0]   lim_data,
    input logic [CNT_W-1:0]     lim_q,
    input logic [DW-1:0]        ch1_smp,
    input logic [DW-1:0]        thr_hi_q,
    input logic [DW-1:0]        thr_lo_q,
    input logic                 lvl_ch1
);

    // R8
    trig_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out);

    // R8
    trig_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && !$past(rearm)) |-> !armed_q);

    // R7
    lim_shadow_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_hi_wr && !lim_lo_wr) |=> $stable(lim_q));

    // R7
    lim_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lim_lo_wr |=> (lim_q[CNT_W/2-1:0] == $past(lim_data)));

    // R2
    hyst_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_smp >= thr_hi_q) |=> lvl_ch1);

    // R2
    hyst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_smp < thr_hi_q && ch1_smp > thr_lo_q) |=> (lvl_ch1 == $past(lvl_ch1)));

endmodule

bind scope_trig scope_trig_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rearm     (rearm),
    .trig_out  (trig_out),
    .armed_q   (armed_q),
    .lim_hi_wr (lim_hi_wr),
    .lim_lo_wr (lim_lo_wr),
    .lim_data  (lim_data),
    .lim_q     (lim_q),
    .ch1_smp   (ch1_smp),
    .thr_hi_q  (thr_hi_q),
    .thr_lo_q  (thr_lo_q),
    .lvl_ch1   (lvl[0])
);

// File: tb/tb_scope_trig.sv
// Testbench for scope_trig: a vector table for hysteresis, then directed tests.
module tb_scope_trig;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  ch1_smp, ch2_smp;
    logic        ext_in, thr_wr, cfg_wr, lim_hi_wr, lim_lo_wr, rearm;
    logic [15:0] thr_data, lim_data;
    logic [4:0]  cfg_data;
    logic [3:0]  lim_data_s;
    logic        trig_out, trig_sat;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    scope_trig dut (
        .clk(clk), .rst_n(rst_n), .ch1_smp(ch1_smp), .ch2_smp(ch2_smp), .ext_in(ext_in),
        .thr_wr(thr_wr), .thr_data(thr_data), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .lim_hi_wr(lim_hi_wr), .lim_lo_wr(lim_lo_wr), .lim_data(lim_data),
        .rearm(rearm), .trig_out(trig_out)
    );

    // Small-counter instance used only to reach saturation.
    scope_trig #(.DW(8), .CNT_W(8)) dut_sat (
        .clk(clk), .rst_n(rst_n), .ch1_smp(ch1_smp), .ch2_smp(ch2_smp), .ext_in(ext_in),
        .thr_wr(thr_wr), .thr_data(thr_data), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .lim_hi_wr(lim_hi_wr), .lim_lo_wr(lim_lo_wr), .lim_data(lim_data_s),
        .rearm(rearm), .trig_out(trig_sat)
    );

    // {expected trig_out, ch1 sample}; default thresholds 0xC0/0x40, CH1 rising, rearm high (R2, R5)
    localparam logic [8:0] VEC [10] = '{
        {1'b0, 8'h00}, {1'b0, 8'h80}, {1'b1, 8'hC0}, {1'b0, 8'h80}, {1'b0, 8'h41},
        {1'b0, 8'hC5}, {1'b0, 8'h40}, {1'b0, 8'h90}, {1'b1, 8'hFF}, {1'b0, 8'h3F}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit act, input bit exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [4:0] d);
        cfg_data = d; cfg_wr = 1'b1; tick(1); cfg_wr = 1'b0;
    endtask

    task automatic wr_thr(input logic [15:0] d);
        thr_data = d; thr_wr = 1'b1; tick(1); thr_wr = 1'b0;
    endtask

    task automatic wr_hi(input logic [15:0] d, input logic [3:0] ds);
        lim_data = d; lim_data_s = ds; lim_hi_wr = 1'b1; tick(1); lim_hi_wr = 1'b0;
    endtask

    task automatic wr_lo(input logic [15:0] d, input logic [3:0] ds);
        lim_data = d; lim_data_s = ds; lim_lo_wr = 1'b1; tick(1); lim_lo_wr = 1'b0;
    endtask

    // Watch both outputs for n cycles.
    task automatic watch(input int n, output bit f, output bit fs);
        f = 1'b0; fs = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            f  = f | trig_out;
            fs = fs | trig_sat;
        end
    endtask

    // Drive a pulse of w clocks on ch1 and report whether either instance fired.
    task automatic pulse(input bit pos, input int w, output bit f, output bit fs);
        ch1_smp = pos ? 8'hFF : 8'h00;
        tick(w);
        ch1_smp = pos ? 8'h00 : 8'hFF;
        watch(5, f, fs);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        bit f, fs;
        rst_n = 1'b0; ch1_smp = 8'h00; ch2_smp = 8'h00; ext_in = 1'b0;
        thr_wr = 1'b0; cfg_wr = 1'b0; lim_hi_wr = 1'b0; lim_lo_wr = 1'b0;
        thr_data = '0; cfg_data = '0; lim_data = '0; lim_data_s = '0; rearm = 1'b1;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check(trig_out, 1'b0, "R1 reset output");

        // Table walk: hysteresis and rising latency, relying on reset defaults (R1, R2, R5)
        foreach (VEC[i]) begin
            ch1_smp = VEC[i][7:0];
            @(posedge clk); @(posedge clk); @(negedge clk);
            check(trig_out, VEC[i][8], $sformatf("R2 vector %0d", i));
        end

        // R2: new thresholds 0x20/0x10
        wr_thr(16'h2010);
        ch1_smp = 8'h00; tick(3);
        ch1_smp = 8'h20; tick(2);
        check(trig_out, 1'b1, "R2 new upper threshold");
        wr_thr(16'hC040);

        // R3 and R5: CH2 falling; CH1 activity ignored
        ch1_smp = 8'h00; ch2_smp = 8'hFF;
        wr_cfg(5'b00101); tick(3);
        ch1_smp = 8'hFF; tick(3); ch1_smp = 8'h00;
        watch(5, f, fs);
        check(f, 1'b0, "R3 unselected ch1 ignored");
        ch2_smp = 8'h00; tick(1);
        check(trig_out, 1'b0, "R5 falling not yet");
        tick(1);
        check(trig_out, 1'b1, "R5 falling latency");

        // R4: external source, 3-cycle latency, analog bypassed
        wr_cfg(5'b00010); tick(3);
        ch1_smp = 8'hFF;
        watch(5, f, fs);
        check(f, 1'b0, "R4 ch1 ignored with external source");
        ch1_smp = 8'h00;
        ext_in = 1'b1; tick(2);
        check(trig_out, 1'b0, "R4 sync delay");
        tick(1);
        check(trig_out, 1'b1, "R4 external trigger");
        ext_in = 1'b0;

        // R8: one-shot and re-arm
        wr_cfg(5'b00000); rearm = 1'b0; tick(3);
        ch1_smp = 8'hFF; tick(2);
        check(trig_out, 1'b1, "R8 first trigger");
        tick(1);
        check(trig_out, 1'b0, "R8 single cycle");
        ch1_smp = 8'h00; tick(3);
        ch1_smp = 8'hFF;
        watch(5, f, fs);
        check(f, 1'b0, "R8 disarmed");
        ch1_smp = 8'h00; tick(3);
        rearm = 1'b1; tick(1); rearm = 1'b0;
        ch1_smp = 8'hFF;
        watch(5, f, fs);
        check(f, 1'b1, "R8 re-armed");
        ch1_smp = 8'h00; rearm = 1'b1; tick(3);

        // R6: positive pulse, limit 5
        wr_hi(16'h0000, 4'h0); wr_lo(16'h0005, 4'h5);
        wr_cfg(5'b01000); tick(3);
        pulse(1'b1, 3, f, fs); check(f, 1'b1, "R6 width 3 < 5");
        pulse(1'b1, 5, f, fs); check(f, 1'b0, "R6 width 5 not < 5");
        pulse(1'b1, 4, f, fs); check(f, 1'b1, "R6 width 4 < 5");
        wr_cfg(5'b11000); tick(2);
        pulse(1'b1, 7, f, fs); check(f, 1'b1, "R6 width 7 > 5");
        pulse(1'b1, 5, f, fs); check(f, 1'b0, "R6 width 5 not > 5");
        pulse(1'b1, 6, f, fs); check(f, 1'b1, "R6 width 6 > 5");

        // R6: negative pulse, greater-than
        ch1_smp = 8'hFF; tick(3);
        wr_cfg(5'b11100); tick(2);
        pulse(1'b0, 8, f, fs); check(f, 1'b1, "R6 negative width 8 > 5");
        pulse(1'b0, 2, f, fs); check(f, 1'b0, "R6 negative width 2 not > 5");

        // R7: upper half alone is not applied
        ch1_smp = 8'h00; tick(3);
        wr_cfg(5'b11000); tick(2);
        wr_hi(16'h0001, 4'h0);
        pulse(1'b1, 7, f, fs); check(f, 1'b1, "R7 limit unchanged after upper write");
        wr_lo(16'h0005, 4'h5);
        pulse(1'b1, 7, f, fs); check(f, 1'b0, "R7 limit 0x10005 committed");

        // R9: 8-bit counter saturates at 255 > 254
        wr_hi(16'h0000, 4'hF); wr_lo(16'h0000, 4'hE);
        pulse(1'b1, 300, f, fs);
        check(fs, 1'b1, "R9 saturated width fires");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule